// File: doc/BRIEF.md
# Multicycle Processor Datapath

This block is the storage and arithmetic half of a 32-bit processor that spends several clock cycles on each instruction and shares a single memory port between instruction fetch and data access. It keeps the program counter, an instruction register, a memory-data latch, two operand latches and an ALU result latch. It also contains a 32-entry register file, one ALU with a zero flag, and the multiplexers that route values between these parts. It holds no sequencing logic. Every select and every enable arrives on plain control pins from an external controller. The datapath returns the opcode and function fields of the held instruction so that the controller can pick its next step.

The memory side has fixed timing rather than a handshake. The block presents an address and store data, and the memory must return read data in the same cycle. The datapath latches that data at the next edge. The controller drives the memory's read and write strobes directly. Because one ALU and one memory port serve every phase, the controller steers each cycle through the selects: fetch and PC increment, branch-target precompute, execute, memory access and write-back.

Top module: `mc_datapath`

## Requirements
- R1: `mem_addr` equals the program counter when `ctl_addr_sel`=0 and the ALU result latch when `ctl_addr_sel`=1.
- R2: ALU operand A is the program counter when `ctl_a_sel`=0 and the A latch when `ctl_a_sel`=1.
- R3: ALU operand B follows `ctl_b_sel`: 0 gives the B latch, 1 gives the constant 4, 2 gives instruction bits [15:0] sign-extended to 32 bits, and 3 gives that sign-extended value shifted left by two.
- R4: The register file is read at instruction fields [25:21] (into the A latch) and [20:16] (into the B latch). Writes go to field [15:11] when `ctl_dst_sel`=1 and to field [20:16] when `ctl_dst_sel`=0.
- R5: `ctl_alu_op` selects the ALU function: 3'b010 add, 3'b110 subtract (A minus B), 3'b000 bitwise and, 3'b001 bitwise or, 3'b111 signed set-less-than (result 1 or 0). `alu_zero` is 1 exactly when the live ALU result is all zeros.
- R6: Register write data is the memory-data latch when `ctl_wb_sel`=1 and the ALU result latch when `ctl_wb_sel`=0. The write takes place at the clock edge only when `ctl_rf_we`=1.
- R7: The program counter loads at an edge when `ctl_pc_we`=1, or when `ctl_pc_we_zero`=1 and `alu_zero`=1. Otherwise it holds. The loaded value follows `ctl_pc_src`: 0 gives the live ALU result, 1 gives the ALU result latch, and 2 gives {PC[31:28], instruction[25:0], 2'b00}.
- R8: The instruction register captures `mem_rdata` only at edges where `ctl_ir_we`=1. `opcode` shows its bits [31:26] and `funct` shows its bits [5:0].
- R9: Register 0 always reads as zero. A write to it has no effect.
- R10: An active-low `rst_n` clears the program counter, the instruction register, all latches and all registers to zero.
- R11: The A, B, memory-data and ALU result latches load at every clock edge. `mem_wdata` is the B latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_addr_sel | input | 1 | Memory address source: 0 PC, 1 ALU result latch |
| ctl_ir_we | input | 1 | Instruction register load enable |
| ctl_a_sel | input | 1 | ALU A source: 0 PC, 1 A latch |
| ctl_b_sel | input | 2 | ALU B source: B latch, 4, immediate, immediate x4 |
| ctl_alu_op | input | 3 | ALU function code |
| ctl_pc_src | input | 2 | Next-PC source: live ALU, ALU latch, jump target |
| ctl_pc_we | input | 1 | Unconditional PC load |
| ctl_pc_we_zero | input | 1 | PC load when the ALU result is zero |
| ctl_dst_sel | input | 1 | Destination field: 0 bits [20:16], 1 bits [15:11] |
| ctl_wb_sel | input | 1 | Write-back source: 0 ALU latch, 1 memory-data latch |
| ctl_rf_we | input | 1 | Register file write enable |
| mem_rdata | input | 32 | Memory read data, valid in the same cycle as the address |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Store data (B latch) |
| opcode | output | 6 | Instruction bits [31:26] |
| funct | output | 6 | Instruction bits [5:0] |
| alu_zero | output | 1 | Live ALU result is zero |
| pc_out | output | 32 | Current program counter |

## Verification
A wrong program counter shows on `pc_out`, and on `mem_addr` during fetch, in the cycle after the faulty load. A wrong instruction register shows at once on `opcode` and `funct`, and one edge later it steers the register reads to the wrong entries. A corrupted register file entry stays hidden until an instruction names it. It then appears on `mem_wdata` one edge after the B latch reads it, or on `mem_addr` two edges after it passes through the ALU into the result latch. Each test therefore runs whole instruction sequences and checks the values where they later surface, not only where they are written.

// File: rtl/mc_pkg.sv
package mc_pkg;

  // ALU function codes seen on ctl_alu_op
  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;

  // operand B sources
  typedef enum logic [1:0] {
    BSRC_REG    = 2'd0,
    BSRC_FOUR   = 2'd1,
    BSRC_IMM    = 2'd2,
    BSRC_IMM_X4 = 2'd3
  } bsrc_e;

  // next program counter sources
  typedef enum logic [1:0] {
    NPC_ALU   = 2'd0,
    NPC_LATCH = 2'd1,
    NPC_JUMP  = 2'd2
  } npc_e;

endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  parameter int NRD   = 2,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NRD-1:0][AW-1:0]  ra,
  output logic [NRD-1:0][W-1:0]   rd,
  input  logic                    we,
  input  logic [AW-1:0]           wa,
  input  logic [W-1:0]            wd
);

  logic [W-1:0] store_q [DEPTH];

  // entry 0 is never written, so it stays at its reset value
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) store_q[i] <= '0;
    end else if (we && (wa != '0)) begin
      store_q[wa] <= wd;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd[g] = (ra[g] == '0) ? '0 : store_q[ra[g]];
  end

endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   op,
  output logic [W-1:0] y,
  output logic         zero
);

  logic lt;
  assign lt = ($signed(a) < $signed(b));

  always_comb begin
    case (alu_op_e'(op))
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(W-1){1'b0}}, lt};
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/mc_opnd.sv
module mc_opnd
  import mc_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 16
) (
  input  logic [W-1:0]     pc,
  input  logic [W-1:0]     a_q,
  input  logic [W-1:0]     b_q,
  input  logic [IMM_W-1:0] imm,
  input  logic             a_sel,
  input  logic [1:0]       b_sel,
  output logic [W-1:0]     alu_a,
  output logic [W-1:0]     alu_b
);

  localparam int EXT_W = W - IMM_W;

  logic [W-1:0] imm_sx;
  logic [W-1:0] imm_x4;

  assign imm_sx = {{EXT_W{imm[IMM_W-1]}}, imm};
  assign imm_x4 = {imm_sx[W-3:0], 2'b00};

  assign alu_a = a_sel ? a_q : pc;

  always_comb begin
    case (bsrc_e'(b_sel))
      BSRC_REG:    alu_b = b_q;
      BSRC_FOUR:   alu_b = W'(4);
      BSRC_IMM:    alu_b = imm_sx;
      BSRC_IMM_X4: alu_b = imm_x4;
      default:     alu_b = b_q;
    endcase
  end

endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREGS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctl_addr_sel,
  input  logic            ctl_ir_we,
  input  logic            ctl_a_sel,
  input  logic [1:0]      ctl_b_sel,
  input  logic [2:0]      ctl_alu_op,
  input  logic [1:0]      ctl_pc_src,
  input  logic            ctl_pc_we,
  input  logic            ctl_pc_we_zero,
  input  logic            ctl_dst_sel,
  input  logic            ctl_wb_sel,
  input  logic            ctl_rf_we,
  input  logic [XLEN-1:0] mem_rdata,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  output logic [5:0]      opcode,
  output logic [5:0]      funct,
  output logic            alu_zero,
  output logic [XLEN-1:0] pc_out
);

  localparam int RAW    = $clog2(NREGS);
  localparam int OPC_W  = 6;
  localparam int FN_W   = 6;
  localparam int IMM_W  = 16;
  localparam int RS_LSB = XLEN - OPC_W - RAW;
  localparam int RT_LSB = RS_LSB - RAW;
  localparam int RD_LSB = RT_LSB - RAW;
  localparam int JIX_W  = XLEN - OPC_W;
  localparam int PCHI_W = XLEN - JIX_W - 2;

  logic [XLEN-1:0] pc_q, ir_q, mdr_q, a_q, b_q, res_q;
  logic [XLEN-1:0] alu_a, alu_b, alu_y;
  logic [XLEN-1:0] pc_nxt, jmp_tgt, wb_data;
  logic [RAW-1:0]  rs_f, rt_f, rd_f, wr_idx;
  logic [1:0][RAW-1:0]  rf_ra;
  logic [1:0][XLEN-1:0] rf_rd;
  logic            pc_en;

  // instruction fields
  assign rs_f = ir_q[RS_LSB +: RAW];
  assign rt_f = ir_q[RT_LSB +: RAW];
  assign rd_f = ir_q[RD_LSB +: RAW];

  assign rf_ra[0] = rs_f;
  assign rf_ra[1] = rt_f;
  assign wr_idx   = ctl_dst_sel ? rd_f : rt_f;
  assign wb_data  = ctl_wb_sel ? mdr_q : res_q;

  mc_regfile #(.W(XLEN), .DEPTH(NREGS), .NRD(2)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .ra    (rf_ra),
    .rd    (rf_rd),
    .we    (ctl_rf_we),
    .wa    (wr_idx),
    .wd    (wb_data)
  );

  mc_opnd #(.W(XLEN), .IMM_W(IMM_W)) u_opnd (
    .pc    (pc_q),
    .a_q   (a_q),
    .b_q   (b_q),
    .imm   (ir_q[IMM_W-1:0]),
    .a_sel (ctl_a_sel),
    .b_sel (ctl_b_sel),
    .alu_a (alu_a),
    .alu_b (alu_b)
  );

  mc_alu #(.W(XLEN)) u_alu (
    .a    (alu_a),
    .b    (alu_b),
    .op   (ctl_alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // next program counter
  assign jmp_tgt = {pc_q[XLEN-1 -: PCHI_W], ir_q[JIX_W-1:0], 2'b00};

  always_comb begin
    case (npc_e'(ctl_pc_src))
      NPC_ALU:   pc_nxt = alu_y;
      NPC_LATCH: pc_nxt = res_q;
      NPC_JUMP:  pc_nxt = jmp_tgt;
      default:   pc_nxt = res_q;
    endcase
  end

  assign pc_en = ctl_pc_we | (ctl_pc_we_zero & alu_zero);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (pc_en) begin
      pc_q <= pc_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q <= '0;
    end else if (ctl_ir_we) begin
      ir_q <= mem_rdata;
    end
  end

  // free-running latches between phases
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdr_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
      res_q <= '0;
    end else begin
      mdr_q <= mem_rdata;
      a_q   <= rf_rd[0];
      b_q   <= rf_rd[1];
      res_q <= alu_y;
    end
  end

  assign mem_addr  = ctl_addr_sel ? res_q : pc_q;
  assign mem_wdata = b_q;
  assign opcode    = ir_q[XLEN-1 -: OPC_W];
  assign funct     = ir_q[FN_W-1:0];
  assign pc_out    = pc_q;

endmodule

// File: rtl/mc_datapath_chk.sv
module mc_datapath_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_addr_sel,
  input logic        ctl_ir_we,
  input logic        ctl_a_sel,
  input logic [1:0]  ctl_b_sel,
  input logic [2:0]  ctl_alu_op,
  input logic [1:0]  ctl_pc_src,
  input logic        ctl_pc_we,
  input logic        ctl_pc_we_zero,
  input logic [5:0]  rdata_top,
  input logic [31:0] mem_addr,
  input logic [5:0]  opcode,
  input logic [5:0]  funct,
  input logic        alu_zero,
  input logic [31:0] pc_out
);

  // R7: with neither load enable the counter holds
  p_pc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_pc_we && !ctl_pc_we_zero) |=> $stable(pc_out));

  // R7: a conditional load with a nonzero ALU result leaves the counter alone
  p_pc_cond_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_pc_we && ctl_pc_we_zero && !alu_zero) |=> $stable(pc_out));

  // R7 with R2, R3, R5: the fetch-increment setting advances the counter by 4
  p_pc_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_pc_we && ctl_pc_src == 2'd0 && !ctl_a_sel && ctl_b_sel == 2'd1
     && ctl_alu_op == 3'b010) |=> (pc_out == $past(pc_out) + 32'd4));

  // R8: the fields hold without the load enable
  p_ir_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_ir_we |=> $stable({opcode, funct}));

  // R8: a load shows the fetched opcode
  p_ir_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_ir_we |=> (opcode == $past(rdata_top)));

  // R1: fetch addressing follows the counter
  p_addr_pc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_addr_sel |-> (mem_addr == pc_out));

  // R10: after a reset edge the counter reads zero
  p_reset_pc_r10: assert property (@(posedge clk)
    !rst_n |=> (pc_out == 32'd0));

endmodule

bind mc_datapath mc_datapath_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ctl_addr_sel   (ctl_addr_sel),
  .ctl_ir_we      (ctl_ir_we),
  .ctl_a_sel      (ctl_a_sel),
  .ctl_b_sel      (ctl_b_sel),
  .ctl_alu_op     (ctl_alu_op),
  .ctl_pc_src     (ctl_pc_src),
  .ctl_pc_we      (ctl_pc_we),
  .ctl_pc_we_zero (ctl_pc_we_zero),
  .rdata_top      (mem_rdata[31:26]),
  .mem_addr       (mem_addr),
  .opcode         (opcode),
  .funct          (funct),
  .alu_zero       (alu_zero),
  .pc_out         (pc_out)
);

// File: tb/mc_datapath_bench.sv
module mc_datapath_bench;

  typedef struct packed {
    logic       addr_sel;
    logic       ir_we;
    logic       a_sel;
    logic [1:0] b_sel;
    logic [2:0] op;
    logic [1:0] pc_src;
    logic       pc_we;
    logic       pc_we_zero;
    logic       dst_sel;
    logic       wb_sel;
    logic       rf_we;
  } ctl_t;

  typedef struct packed {
    ctl_t        c;
    logic [31:0] rdata;
    logic [31:0] pc;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic        zero;
  } vec_t;

  localparam logic [2:0] OP_AND = 3'b000, OP_OR = 3'b001, OP_ADD = 3'b010,
                         OP_SUB = 3'b110, OP_SLT = 3'b111;

  function automatic ctl_t mk(input logic as, input logic irw, input logic asl,
                              input logic [1:0] bs, input logic [2:0] op,
                              input logic [1:0] ps, input logic pw, input logic pz,
                              input logic ds, input logic wb, input logic rw);
    ctl_t c;
    c = '{addr_sel:as, ir_we:irw, a_sel:asl, b_sel:bs, op:op, pc_src:ps,
          pc_we:pw, pc_we_zero:pz, dst_sel:ds, wb_sel:wb, rf_we:rw};
    return c;
  endfunction

  // instruction words: opcode[31:26] rs[25:21] rt[20:16] rd[15:11] imm[15:0]
  localparam logic [31:0] I1 = 32'h8C05_0010; // rs0 rt5 imm 0x0010
  localparam logic [31:0] I2 = 32'h00A5_3820; // rs5 rt5 rd7 funct 0x20
  localparam logic [31:0] I3 = 32'h00E0_0000; // rs7 rt0 rd0
  localparam logic [31:0] I5 = 32'hACE5_802A; // op 0x2B rs7 rt5 imm 0x802A
  localparam logic [31:0] V  = 32'hDEAD_BEEF;
  localparam logic [31:0] S7 = 32'hBD5B_7DDE; // V + V, stored in r7

  localparam ctl_t C_IDLE  = '0;
  localparam ctl_t C_FETCH = mk(0,1,0,2'd1,OP_ADD,2'd0,1,0,0,0,0);

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{C_FETCH,                                      I1, 32'd4,  32'd4,        32'd0, 1'b0},
    '{mk(1,0,0,2'd3,OP_ADD,2'd0,0,0,0,0,0),         V,  32'd4,  32'h44,       32'd0, 1'b0},
    '{mk(0,0,0,2'd0,OP_ADD,2'd0,0,0,0,1,1),         0,  32'd4,  32'd4,        32'd0, 1'b0},
    '{C_IDLE,                                       0,  32'd4,  32'd4,        V,     1'b0},
    '{C_FETCH,                                      I2, 32'd8,  32'd8,        V,     1'b0},
    '{mk(1,0,0,2'd3,OP_ADD,2'd0,0,0,0,0,0),         0,  32'd8,  32'hE088,     V,     1'b0},
    '{mk(1,0,1,2'd0,OP_SUB,2'd0,0,0,0,0,0),         0,  32'd8,  32'd0,        V,     1'b1},
    '{mk(1,0,1,2'd0,OP_ADD,2'd0,0,0,0,0,0),         0,  32'd8,  S7,           V,     1'b0},
    '{mk(1,0,1,2'd0,OP_OR, 2'd0,0,0,1,0,1),         0,  32'd8,  V,            V,     1'b0},
    '{C_FETCH,                                      I3, 32'd12, 32'd12,       V,     1'b0},
    '{C_IDLE,                                       0,  32'd12, 32'd12,       32'd0, 1'b1},
    '{mk(1,0,1,2'd1,OP_ADD,2'd0,0,0,0,0,0),         0,  32'd12, 32'hBD5B7DE2, 32'd0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  ctl_t        ctl = '0;
  logic [31:0] mem_rdata = '0;
  logic [31:0] mem_addr, mem_wdata, pc_out;
  logic [5:0]  opcode, funct;
  logic        alu_zero;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  mc_datapath u_mc_datapath (
    .clk            (clk),
    .rst_n          (rst_n),
    .ctl_addr_sel   (ctl.addr_sel),
    .ctl_ir_we      (ctl.ir_we),
    .ctl_a_sel      (ctl.a_sel),
    .ctl_b_sel      (ctl.b_sel),
    .ctl_alu_op     (ctl.op),
    .ctl_pc_src     (ctl.pc_src),
    .ctl_pc_we      (ctl.pc_we),
    .ctl_pc_we_zero (ctl.pc_we_zero),
    .ctl_dst_sel    (ctl.dst_sel),
    .ctl_wb_sel     (ctl.wb_sel),
    .ctl_rf_we      (ctl.rf_we),
    .mem_rdata      (mem_rdata),
    .mem_addr       (mem_addr),
    .mem_wdata      (mem_wdata),
    .opcode         (opcode),
    .funct          (funct),
    .alu_zero       (alu_zero),
    .pc_out         (pc_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // apply at the falling edge, let one rising edge pass, stop at the next fall
  task automatic step(input ctl_t c, input logic [31:0] rd);
    ctl = c;
    mem_rdata = rd;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: state after reset
    chk("R10 pc", pc_out, 32'd0);
    chk("R10 addr", mem_addr, 32'd0);
    chk("R10 wdata", mem_wdata, 32'd0);
    chk("R10 opcode", {26'd0, opcode}, 32'd0);
    rst_n = 1'b1;

    // R1 R2 R3 R4 R5 R6 R11: table of short instruction sequences
    for (int i = 0; i < NV; i++) begin
      step(TBL[i].c, TBL[i].rdata);
      chk($sformatf("R7 row%0d pc", i), pc_out, TBL[i].pc);
      chk($sformatf("R1 row%0d addr", i), mem_addr, TBL[i].addr);
      chk($sformatf("R11 row%0d wdata", i), mem_wdata, TBL[i].wdata);
      chk($sformatf("R5 row%0d zero", i), {31'd0, alu_zero}, {31'd0, TBL[i].zero});
    end

    // R7: conditional load with a nonzero result does nothing
    step(mk(0,0,1,2'd0,OP_SUB,2'd1,0,1,0,0,0), 0);
    chk("R7 cond not taken", pc_out, 32'd12);
    // R7: zero result takes the latched ALU value
    step(mk(0,0,1,2'd0,OP_AND,2'd1,0,1,0,0,0), 0);
    chk("R7 cond taken", pc_out, S7);
    // R7: jump target {pc[31:28], ir[25:0], 00}
    step(mk(0,0,1,2'd1,OP_ADD,2'd2,1,0,0,0,0), 0);
    chk("R7 jump", pc_out, 32'hB380_0000);

    // R9: write to register 0 through rd (ir rd field = 0), then read back via rt
    step(mk(0,0,0,2'd0,OP_AND,2'd0,0,0,1,0,1), 0);
    step(C_IDLE, 0);
    chk("R9 reg0 reads zero", mem_wdata, 32'd0);

    // R8: fetch a new word, then hold it while memory shows other data
    step(C_FETCH, I5);
    chk("R8 opcode load", {26'd0, opcode}, 32'h2B);
    chk("R8 funct load", {26'd0, funct}, 32'h2A);
    chk("R7 fetch step", pc_out, 32'hB380_0004);
    step(C_IDLE, 32'hFFFF_FFFF);
    chk("R8 opcode hold", {26'd0, opcode}, 32'h2B);
    chk("R8 funct hold", {26'd0, funct}, 32'h2A);
    chk("R4 rt read", mem_wdata, V);

    // R5: signed set-less-than, A=r7 (more negative) B=r5
    step(mk(1,0,1,2'd0,OP_SLT,2'd0,0,0,0,0,0), 0);
    chk("R5 slt", mem_addr, 32'd1);
    // R3: sign-extended immediate 0x802A added to pc
    step(mk(1,0,0,2'd2,OP_ADD,2'd0,0,0,0,0,0), 0);
    chk("R3 sext imm", mem_addr, 32'hB37F_802E);
    // R5: or and and
    step(mk(1,0,1,2'd0,OP_OR,2'd0,0,0,0,0,0), 0);
    chk("R5 or", mem_addr, 32'hFFFF_FFFF);
    step(mk(1,0,1,2'd0,OP_AND,2'd0,0,0,0,0,0), 0);
    chk("R5 and", mem_addr, 32'h9C09_3CCE);

    // R10: reset in mid-run
    ctl = C_IDLE;
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R10 pc mid-run", pc_out, 32'd0);
    chk("R10 wdata mid-run", mem_wdata, 32'd0);
    chk("R10 funct mid-run", {26'd0, funct}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    finish_run();
  end

endmodule